// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a small, synthesizable model of a synchronous static RAM whose data bus never needs an idle cycle between a read and a write. Commands are sampled on the rising clock edge. The data for a write arrives a fixed number of cycles after its address, the same number of cycles that a read takes to return data. Because of this, a controller can issue any mix of reads and writes on consecutive clocks, and the shared data bus is busy on every cycle.

A static mode input selects how deep the pipeline is. In pipelined mode, read data passes through an output register and write data is taken two edges after the address. In flow-through mode, read data comes straight from the array and write data is taken one edge after the address. A write is posted until its data arrives. In pipelined mode, a read that overtakes a posted write to the same word gets the write's enabled bytes forwarded to it.

The model also provides per-byte write enables (9-bit bytes), three chip enables for depth expansion, and a four-beat burst continuation with linear or interleaved order. It has an asynchronous output enable and a sleep input. The tri-state data bus is modelled as a data output plus a drive-enable output.

Top module: `zbt_sram`

## Requirements
- R1: While reset is active and on the first cycle after it, `rdata_drv` is 0 and `rdata` is 0; no command issued before reset is carried out.
- R2: A read returns the word as updated by every write issued before it, in issue order.
- R3: With `pipe_mode`=1, read data is driven during the cycle that ends at the second rising edge after the address edge, and write data is sampled at that second edge.
- R4: With `pipe_mode`=0, read data is driven during the cycle that ends at the first rising edge after the address edge, and write data is sampled at that edge.
- R5: A new command is accepted on every clock; reads and writes may alternate on consecutive cycles with no idle cycle between them.
- R6: Byte lane i covers `wdata`/`rdata` bits [9i+8:9i]. `lane_we_n[i]`=0 in a write's address cycle writes that lane, and `lane_we_n[i]`=1 leaves the lane unchanged.
- R7: A new command is accepted only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Any other combination is a deselect cycle: no access is made and the current burst ends.
- R8: `oe_n`=1 forces `rdata_drv` to 0 and `rdata` to 0 in the same cycle, without waiting for a clock edge.
- R9: While `sleep`=1, a command at the edge is ignored and `rdata_drv` and `rdata` are 0. Writes that are already posted still complete.
- R10: `burst_adv`=1 with a burst active issues the burst's next beat with the same direction, ignoring `addr`, `we_n` and the chip enables. The beat address keeps bits [5:2] of the start address. Its low two bits are start+k mod 4 when `burst_lin`=1, and start XOR k when `burst_lin`=0, where k is the beat number 1..3 wrapping. `burst_adv`=1 with no burst active makes no access.
- R11: Burst read beats arrive on consecutive cycles: the first beat after the read latency of R3/R4, then one beat per clock.
- R12: In pipelined mode, a read issued on the cycle after a write to the same address returns the write's enabled lanes merged over the stored lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| burst_lin | input | 1 | Static: 1 linear burst order, 0 interleaved |
| sleep | input | 1 | Power-down request; blocks commands and output |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| burst_adv | input | 1 | Continue the active burst by one beat |
| we_n | input | 1 | 0 write, 1 read |
| lane_we_n | input | 2 | Per-lane write enable, active low |
| addr | input | 6 | Word address |
| wdata | input | 18 | Write data, sampled at the late-write edge |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 18 | Read data, 0 when not driven |
| rdata_drv | output | 1 | Data bus drive enable (0 = high impedance) |

## Verification
On every cycle the assertions check the following. Sleep and deselect cycles leave the command stage empty. A selected command is captured with its address and direction. In pipelined mode, a write reaches the array exactly one edge after it leaves the command stage, and a read fills the output register. Read data values, lane merging, forwarding from a posted write, burst address order and the same-cycle effect of the output enable can only be shown by the bench's scenarios, which compare each data-bus cycle against a reference memory updated at issue time.

// File: rtl/zbt_pkg.sv
// Shared types and helpers for the zero-turnaround SRAM model.
// Assumes bursts are four beats, stepping the two low address bits.
package zbt_pkg;
    typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;

    // Low address bits of burst beat k from start bits, linear or interleaved.
    function automatic logic [1:0] burst_low(input logic lin,
                                             input logic [1:0] start,
                                             input logic [1:0] k);
        return lin ? (start + k) : (start ^ k);
    endfunction
endpackage

// File: rtl/zbt_cmd.sv
// Command stage: decodes chip enables, sleep and burst continuation, and
// registers one accepted operation per clock (stage 1).
// Assumes ADDR_W >= 3; lane enables are sampled with each beat.
module zbt_cmd
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              burst_lin,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              burst_adv,
    input  logic              we_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              s1_valid,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_lanes
);
    logic              sel;
    logic              issue;
    op_e               op_n;
    logic [ADDR_W-1:0] addr_n;
    logic              burst_act;
    logic [ADDR_W-1:0] base;
    logic [1:0]        cnt;
    op_e               last_op;

    assign sel = !ce_a_n && ce_b && !ce_c_n;

    // Choose the operation to issue this cycle: burst beat, new command or none.
    always_comb begin
        issue  = 1'b0;
        op_n   = last_op;
        addr_n = addr;
        if (!sleep) begin
            if (burst_adv) begin
                if (burst_act) begin
                    issue  = 1'b1;
                    addr_n = {base[ADDR_W-1:2], burst_low(burst_lin, base[1:0], cnt + 2'd1)};
                end
            end else if (sel) begin
                issue = 1'b1;
                op_n  = we_n ? OP_RD : OP_WR;
            end
        end
    end

    // Register the issued operation into stage 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_RD;
            s1_addr  <= '0;
            s1_lanes <= '0;
        end else begin
            s1_valid <= issue;
            if (issue) begin
                s1_op    <= op_n;
                s1_addr  <= addr_n;
                s1_lanes <= ~lane_we_n;
            end
        end
    end

    // Track burst start, beat count and direction; a deselect ends the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_act <= 1'b0;
            base      <= '0;
            cnt       <= '0;
            last_op   <= OP_RD;
        end else if (!sleep) begin
            if (burst_adv) begin
                if (burst_act) cnt <= cnt + 2'd1;
            end else if (sel) begin
                burst_act <= 1'b1;
                base      <= addr;
                cnt       <= '0;
                last_op   <= op_n;
            end else begin
                burst_act <= 1'b0;
            end
        end
    end

    a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !s1_valid);
    a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !burst_adv && !sel) |=> !s1_valid);
    a_r5_issue_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !burst_adv && sel) |=>
        (s1_valid && s1_addr == $past(addr) && s1_op == ($past(we_n) ? OP_RD : OP_WR)));
endmodule

// File: rtl/zbt_array.sv
// Storage array: one memory per byte lane, synchronous lane-masked write,
// combinational read. Not reset, like a real static RAM.
module zbt_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];

        // Write this lane when the commit selects it.
        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[i]) mem[wr_addr] <= wr_data[i*BYTE_W +: BYTE_W];
        end

        assign rd_data[i*BYTE_W +: BYTE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/zbt_rdpath.sv
// Read path: forwards a posted write in stage 2 to a read in stage 1
// (pipelined mode only), holds the pipelined output register and picks the
// read source for the selected mode.
module zbt_rdpath
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    s1_valid,
    input  op_e                     s1_op,
    input  logic [ADDR_W-1:0]       s1_addr,
    input  logic                    s2_valid,
    input  op_e                     s2_op,
    input  logic [ADDR_W-1:0]       s2_addr,
    input  logic [LANES-1:0]        s2_lanes,
    input  logic [LANES*BYTE_W-1:0] wdata,
    input  logic [LANES*BYTE_W-1:0] arr_data,
    output logic                    rd_active,
    output logic [LANES*BYTE_W-1:0] rd_word
);
    localparam int DATA_W = LANES * BYTE_W;

    logic              hit;
    logic              s1_rd;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] out_q;
    logic              out_v;

    assign s1_rd = s1_valid && (s1_op == OP_RD);
    assign hit   = pipe_mode && s2_valid && (s2_op == OP_WR) && (s2_addr == s1_addr);

    for (genvar i = 0; i < LANES; i++) begin : g_fwd
        assign merged[i*BYTE_W +: BYTE_W] = (hit && s2_lanes[i]) ?
            wdata[i*BYTE_W +: BYTE_W] : arr_data[i*BYTE_W +: BYTE_W];
    end

    // Pipelined output register: capture the merged read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_q <= '0;
        end else begin
            out_v <= s1_rd;
            if (s1_rd) out_q <= merged;
        end
    end

    assign rd_active = pipe_mode ? out_v : s1_rd;
    assign rd_word   = pipe_mode ? out_q : arr_data;

    a_r3_pipe_out_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && s1_rd) |=> rd_active);
endmodule

// File: rtl/zbt_sram.sv
// Top of the zero-turnaround SRAM model. Stage 1 holds the accepted command,
// stage 2 delays it one more cycle; a write commits from stage 2 in pipelined
// mode and from stage 1 in flow-through mode, using the data on wdata then.
// Assumes pipe_mode and burst_lin change only while idle or in reset.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pipe_mode,
    input  logic                    burst_lin,
    input  logic                    sleep,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    burst_adv,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*BYTE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*BYTE_W-1:0] rdata,
    output logic                    rdata_drv
);
    localparam int DATA_W = LANES * BYTE_W;

    logic              s1_valid, s2_valid;
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_lanes, s2_lanes;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [LANES-1:0]  arr_wlanes;
    logic [DATA_W-1:0] arr_rdata;
    logic              rd_active;
    logic [DATA_W-1:0] rd_word;

    zbt_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .burst_lin(burst_lin),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .burst_adv(burst_adv),
        .we_n(we_n), .lane_we_n(lane_we_n), .addr(addr),
        .s1_valid(s1_valid), .s1_op(s1_op), .s1_addr(s1_addr), .s1_lanes(s1_lanes)
    );

    // Stage 2: second late-write slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_op    <= OP_RD;
            s2_addr  <= '0;
            s2_lanes <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_op    <= s1_op;
            s2_addr  <= s1_addr;
            s2_lanes <= s1_lanes;
        end
    end

    // Pick the commit slot for the selected late-write depth.
    always_comb begin
        if (pipe_mode) begin
            arr_we     = s2_valid && (s2_op == OP_WR);
            arr_waddr  = s2_addr;
            arr_wlanes = s2_lanes;
        end else begin
            arr_we     = s1_valid && (s1_op == OP_WR);
            arr_waddr  = s1_addr;
            arr_wlanes = s1_lanes;
        end
    end

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_array (
        .clk(clk), .wr_en(arr_we), .wr_addr(arr_waddr), .wr_lanes(arr_wlanes),
        .wr_data(wdata), .rd_addr(s1_addr), .rd_data(arr_rdata)
    );

    zbt_rdpath #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_rdpath (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
        .s1_valid(s1_valid), .s1_op(s1_op), .s1_addr(s1_addr),
        .s2_valid(s2_valid), .s2_op(s2_op), .s2_addr(s2_addr), .s2_lanes(s2_lanes),
        .wdata(wdata), .arr_data(arr_rdata),
        .rd_active(rd_active), .rd_word(rd_word)
    );

    assign rdata_drv = rd_active && !oe_n && !sleep;
    assign rdata     = rdata_drv ? rd_word : '0;

    a_r3_double_late_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && s1_valid && s1_op == OP_WR) |=>
        (arr_we && arr_waddr == $past(s1_addr) && arr_wlanes == $past(s1_lanes)));
endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
    localparam int AW = 6;
    localparam int LN = 2;
    localparam int BW = 9;
    localparam int DW = LN * BW;
    localparam int NP = 64;
    localparam int NV = 16;
    localparam logic [DW-1:0] FILLER = 18'h2AAAA;

    // Vector: {kind(0 idle,1 read,2 write,3 burst beat), addr, lane enables (1 = write), data}
    localparam logic [27:0] VEC [NV] = '{
        {2'd2, 6'd5,  2'b11, 18'h12345},
        {2'd1, 6'd5,  2'b00, 18'h00000},
        {2'd2, 6'd6,  2'b11, 18'h2ABCD},
        {2'd1, 6'd6,  2'b00, 18'h00000},
        {2'd2, 6'd5,  2'b01, 18'h3FFFF},
        {2'd1, 6'd5,  2'b00, 18'h00000},
        {2'd1, 6'd6,  2'b00, 18'h00000},
        {2'd2, 6'd7,  2'b11, 18'h00111},
        {2'd2, 6'd7,  2'b10, 18'h3FE00},
        {2'd1, 6'd7,  2'b00, 18'h00000},
        {2'd0, 6'd0,  2'b00, 18'h00000},
        {2'd1, 6'd5,  2'b00, 18'h00000},
        {2'd2, 6'd10, 2'b11, 18'h1C3C3},
        {2'd1, 6'd10, 2'b00, 18'h00000},
        {2'd1, 6'd7,  2'b00, 18'h00000},
        {2'd0, 6'd0,  2'b00, 18'h00000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b1;
    logic          burst_lin = 1'b1;
    logic          sleep = 1'b0;
    logic          ce_a_n = 1'b1;
    logic          ce_b = 1'b0;
    logic          ce_c_n = 1'b1;
    logic          burst_adv = 1'b0;
    logic          we_n = 1'b1;
    logic [LN-1:0] lane_we_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int n_run = 0;
    int n_fail = 0;

    logic [1:0]    pk  [NP];
    logic [AW-1:0] pa  [NP];
    logic [LN-1:0] pl  [NP];
    logic [DW-1:0] pd  [NP];
    logic [2:0]    pce [NP];
    logic          poe [NP];
    logic          psl [NP];
    logic          ev  [NP];
    logic [DW-1:0] ed  [NP];
    logic          wv  [NP];
    logic [DW-1:0] wq  [NP];
    logic [DW-1:0] refm [1 << AW];
    logic          bact = 1'b0;
    logic [AW-1:0] bbase = '0;
    logic [1:0]    bcnt = '0;
    logic [1:0]    bkind = 2'd1;

    always #2 clk = ~clk;

    zbt_sram dut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_lin(burst_lin),
        .sleep(sleep), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .burst_adv(burst_adv), .we_n(we_n), .lane_we_n(lane_we_n), .addr(addr),
        .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_drv(rdata_drv)
    );

    task automatic check(input string tag, input logic exp_drv, input logic [DW-1:0] exp_d);
        n_run++;
        if (rdata_drv !== exp_drv || rdata !== exp_d) begin
            n_fail++;
            $display("FAIL %s: drv=%0b data=%h expected drv=%0b data=%h",
                     tag, rdata_drv, rdata, exp_drv, exp_d);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < NP; i++) begin
            pk[i] = 2'd0; pa[i] = '0; pl[i] = '0; pd[i] = '0;
            pce[i] = 3'b000; poe[i] = 1'b0; psl[i] = 1'b0;
        end
    endtask

    task automatic put(input int i, input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [LN-1:0] l, input logic [DW-1:0] d);
        pk[i] = k; pa[i] = a; pl[i] = l; pd[i] = d;
    endtask

    // Reference model at issue time: burst rules of R10, chip enables of R7, sleep of R9.
    task automatic model(input int c);
        logic [1:0]    kind;
        logic [AW-1:0] ea;
        logic [1:0]    low;
        kind = 2'd0;
        ea   = pa[c];
        if (psl[c]) begin
            kind = 2'd0;
        end else if (pk[c] == 2'd3) begin
            if (bact) begin
                bcnt = bcnt + 2'd1;
                low  = burst_lin ? 2'((bbase[1:0] + bcnt) % 4) : (bbase[1:0] ^ bcnt);
                ea   = {bbase[AW-1:2], low};
                kind = bkind;
            end
        end else if ((pk[c] == 2'd1 || pk[c] == 2'd2) && pce[c] == 3'b000) begin
            bact = 1'b1; bbase = pa[c]; bcnt = 2'd0; bkind = pk[c];
            kind = pk[c];
        end else begin
            bact = 1'b0;
        end
        if (kind == 2'd2) begin
            for (int j = 0; j < LN; j++)
                if (pl[c][j]) refm[ea][j*BW +: BW] = pd[c][j*BW +: BW];
            wv[c] = 1'b1; wq[c] = pd[c];
        end else if (kind == 2'd1) begin
            ev[c] = 1'b1; ed[c] = refm[ea];
        end
    endtask

    task automatic run_prog(input int n, input string tag);
        int d;
        d = pipe_mode ? 2 : 1;
        for (int i = 0; i < NP; i++) begin ev[i] = 1'b0; wv[i] = 1'b0; end
        for (int c = 0; c < n + d; c++) begin
            @(negedge clk);
            oe_n  = (c < n) ? poe[c] : 1'b0;
            sleep = (c < n) ? psl[c] : 1'b0;
            if (c < n) begin
                burst_adv = (pk[c] == 2'd3);
                we_n      = (pk[c] != 2'd2);
                addr      = pa[c];
                lane_we_n = ~pl[c];
                if (pk[c] == 2'd1 || pk[c] == 2'd2) begin
                    ce_a_n = pce[c][0]; ce_b = !pce[c][1]; ce_c_n = pce[c][2];
                end else begin
                    ce_a_n = 1'b1; ce_b = 1'b1; ce_c_n = 1'b0;
                end
                model(c);
            end else begin
                burst_adv = 1'b0; we_n = 1'b1; ce_a_n = 1'b1; lane_we_n = '1;
            end
            wdata = (c >= d && wv[c-d]) ? wq[c-d] : FILLER;
            #1;
            if (c >= d && ev[c-d] && !oe_n && !sleep) check(tag, 1'b1, ed[c-d]);
            else check(tag, 1'b0, '0);
        end
        @(negedge clk);
        burst_adv = 1'b0; we_n = 1'b1; ce_a_n = 1'b1; oe_n = 1'b0; sleep = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; pipe_mode = mode;
        burst_adv = 1'b0; ce_a_n = 1'b1; sleep = 1'b0; oe_n = 1'b0;
        bact = 1'b0;
        repeat (2) @(negedge clk);
        #1 check("R1", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R1", 1'b0, '0);
    endtask

    task automatic run_table(input string tag);
        clear_prog();
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            put(i, v[27:26], v[25:20], v[19:18], v[17:0]);
        end
        run_prog(NV, tag);
    endtask

    task automatic directed();
        // R8: output enable high during a read's data cycle
        clear_prog();
        put(0, 2'd2, 6'd30, 2'b11, 18'h0F0F0);
        put(1, 2'd1, 6'd30, 2'b00, 18'h0);
        put(2, 2'd1, 6'd30, 2'b00, 18'h0);
        poe[pipe_mode ? 3 : 2] = 1'b1;
        run_prog(5, "R8");
        // R9: sleep at a write's issue drops it; sleep in a data cycle blanks the output
        clear_prog();
        put(0, 2'd2, 6'd31, 2'b11, 18'h11111);
        put(2, 2'd2, 6'd31, 2'b11, 18'h22222);
        psl[2] = 1'b1;
        put(4, 2'd1, 6'd31, 2'b00, 18'h0);
        put(5, 2'd1, 6'd31, 2'b00, 18'h0);
        psl[pipe_mode ? 7 : 6] = 1'b1;
        run_prog(9, "R9");
        // R7: each chip enable inactive on its own blocks the write
        clear_prog();
        put(0, 2'd2, 6'd32, 2'b11, 18'h0ABCD);
        put(1, 2'd2, 6'd32, 2'b11, 18'h1111F); pce[1] = 3'b001;
        put(2, 2'd2, 6'd32, 2'b11, 18'h2222F); pce[2] = 3'b010;
        put(3, 2'd2, 6'd32, 2'b11, 18'h3333F); pce[3] = 3'b100;
        put(4, 2'd1, 6'd32, 2'b00, 18'h0);
        run_prog(5, "R7");
        // R10/R11: linear burst write, single reads, burst read
        burst_lin = 1'b1;
        clear_prog();
        put(0, 2'd2, 6'd34, 2'b11, 18'h0A001);
        put(1, 2'd3, 6'd0,  2'b11, 18'h0A002);
        put(2, 2'd3, 6'd0,  2'b11, 18'h0A003);
        put(3, 2'd3, 6'd0,  2'b11, 18'h0A004);
        put(5, 2'd1, 6'd32, 2'b00, 18'h0);
        put(6, 2'd1, 6'd33, 2'b00, 18'h0);
        put(7, 2'd1, 6'd34, 2'b00, 18'h0);
        put(8, 2'd1, 6'd35, 2'b00, 18'h0);
        put(9, 2'd1, 6'd33, 2'b00, 18'h0);
        put(10, 2'd3, 6'd0, 2'b00, 18'h0);
        put(11, 2'd3, 6'd0, 2'b00, 18'h0);
        put(12, 2'd3, 6'd0, 2'b00, 18'h0);
        put(13, 2'd3, 6'd0, 2'b00, 18'h0);
        run_prog(14, "R10/R11 linear");
        // R10/R11: interleaved burst write and read
        burst_lin = 1'b0;
        clear_prog();
        put(0, 2'd2, 6'd41, 2'b11, 18'h0B001);
        put(1, 2'd3, 6'd0,  2'b11, 18'h0B002);
        put(2, 2'd3, 6'd0,  2'b11, 18'h0B003);
        put(3, 2'd3, 6'd0,  2'b11, 18'h0B004);
        put(4, 2'd1, 6'd40, 2'b00, 18'h0);
        put(5, 2'd1, 6'd42, 2'b00, 18'h0);
        put(6, 2'd1, 6'd43, 2'b00, 18'h0);
        put(7, 2'd1, 6'd42, 2'b00, 18'h0);
        put(8, 2'd3, 6'd0,  2'b00, 18'h0);
        put(9, 2'd3, 6'd0,  2'b00, 18'h0);
        put(10, 2'd3, 6'd0, 2'b00, 18'h0);
        run_prog(11, "R10/R11 interleaved");
        burst_lin = 1'b1;
        // R10: a beat with no burst active makes no access
        clear_prog();
        put(0, 2'd2, 6'd49, 2'b11, 18'h01234);
        put(1, 2'd2, 6'd48, 2'b11, 18'h05678);
        put(3, 2'd3, 6'd0,  2'b11, 18'h3DEAD);
        put(4, 2'd1, 6'd49, 2'b00, 18'h0);
        run_prog(5, "R10 no burst");
    endtask

    initial begin
        do_reset(1'b0);
        run_table("R4/R2/R5/R6");
        directed();
        do_reset(1'b1);
        run_table("R3/R2/R5/R6/R12");
        directed();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule